// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the shared interrupt control and status register of a multi-channel DMA controller. It holds a small group of software control bits, a per-channel interrupt enable for each of seven channels, a global enable and a forced-error bit. It also holds a completion flag for each channel and a master flag that summarises them. Software writes the whole register with a 32-bit word. Only the control bits can be written this way, and a one written to a flag position clears that flag. Each transfer engine reports its completion with a one-cycle pulse.

The master flag follows a single condition: either the forced-error bit is set, or the global enable is set and at least one completion flag is set. The system interrupt controller does not see this flag as a level. It gets a single-cycle request only in the cycle when the master flag goes from clear to set. The request fires again only after the condition has gone false and then become true again. A read returns the full 32-bit word.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_data` reads 0 and `irq_req` is low.
- R2: A write stores `wr_data & 32'h00FF803F` as the control part. That covers bits 5:0 (general control), bit 15 (forced error), bits 22:16 (enable for channels 0..6) and bit 23 (global enable). The next cycle, bits 14:6 read 0 and bits 23:0 read back that masked value.
- R3: On a write, completion flag n (bit 24+n) is cleared where `wr_data[24+n]` is 1 and kept where it is 0. Writes never set a flag.
- R4: A pulse on `ch_done[n]` sets flag bit 24+n only if enable bit 16+n was already set in the cycle of the pulse. Otherwise the flag is left unchanged.
- R5: If a write clears flag n in the same cycle that `ch_done[n]` pulses with that channel enabled, the set wins and the flag stays at 1.
- R6: Bit 31 of `rd_data` always equals (bit 23 AND any of bits 30:24) OR bit 15. Writing bit 31 has no effect on it.
- R7: `irq_req` is high for exactly the cycle in which bit 31 of `rd_data` first reads 1 after reading 0.
- R8: If bit 31 is already 1, new flags or writes that keep the condition true raise no new request.
- R9: A write that makes the condition false clears bit 31. The next time the condition becomes true, a fresh request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data word |
| ch_done | input | 7 | Per-channel completion pulse, bit n for channel n |
| rd_data | output | 32 | Full register contents |
| irq_req | output | 1 | One-cycle request to the system interrupt controller |

## Verification
Every piece of state can be read on `rd_data` one cycle after the edge that changed it. A wrong mask, a lost or spurious flag, or a stale master bit therefore shows up at the very next sample. The master bit is the only state that is not visible as a separate field. If it is wrong, the fault shows up as a request on `irq_req` that is missing, doubled, or early. It appears in the same cycle as the change of bit 31, or at the next time the condition turns true. For that reason the bench drives long runs that keep the condition true, interleaved with writes that toggle it.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int REG_W     = 32;
    localparam int CH_N      = 7;
    localparam int AUX_W     = 6;
    localparam int FORCE_BIT = 15;
    localparam int EN_LSB    = 16;
    localparam int GLB_BIT   = 23;
    localparam int FLG_LSB   = 24;
    localparam int MST_BIT   = 31;

    // Bits a software write may load directly.
    localparam logic [REG_W-1:0] WR_MASK =
          REG_W'((64'd1 << AUX_W) - 64'd1)
        | REG_W'(64'd1 << FORCE_BIT)
        | REG_W'(((64'd1 << CH_N) - 64'd1) << EN_LSB)
        | REG_W'(64'd1 << GLB_BIT);

    typedef struct packed {
        logic [REG_W-1:0] ctrl;  // masked control word, non-writable bits zero
        logic [CH_N-1:0]  flg;   // per-channel completion flags
        logic             mst;   // master flag
        logic             irq;   // one-cycle request
    } dirq_state_t;

endpackage

// File: rtl/dirq_ctrl_latch.sv
module dirq_ctrl_latch
    import dirq_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] ctrl_d
);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = wr_data & WR_MASK;
        end
    end

endmodule

// File: rtl/dirq_flag_cell.sv
module dirq_flag_cell (
    input  logic flg_q,
    input  logic en_q,
    input  logic done,
    input  logic clr,
    output logic flg_d
);

    // A completion that arrives with the channel enabled outranks a clear.
    always_comb begin
        flg_d = flg_q & ~clr;
        if (done && en_q) begin
            flg_d = 1'b1;
        end
    end

endmodule

// File: rtl/dirq_master_eval.sv
module dirq_master_eval
    import dirq_pkg::*;
(
    input  logic            glb,
    input  logic            force_err,
    input  logic [CH_N-1:0] flg,
    input  logic            mst_q,
    output logic            mst_d,
    output logic            irq_d
);

    logic cond;

    always_comb begin
        cond  = (glb && (|flg)) || force_err;
        mst_d = cond;
        irq_d = cond && !mst_q;
    end

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [CH_N-1:0]  ch_done,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_req
);

    dirq_state_t state_q;
    dirq_state_t state_d;

    logic [REG_W-1:0] ctrl_d;
    logic [CH_N-1:0]  flg_d;
    logic [CH_N-1:0]  clr_vec;
    logic [CH_N-1:0]  en_q;
    logic             mst_d;
    logic             irq_d;

    assign en_q    = state_q.ctrl[EN_LSB +: CH_N];
    assign clr_vec = wr_en ? wr_data[FLG_LSB +: CH_N] : '0;

    dirq_ctrl_latch u_ctrl (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (state_q.ctrl),
        .ctrl_d  (ctrl_d)
    );

    for (genvar gi = 0; gi < CH_N; gi++) begin : g_flag
        dirq_flag_cell u_cell (
            .flg_q (state_q.flg[gi]),
            .en_q  (en_q[gi]),
            .done  (ch_done[gi]),
            .clr   (clr_vec[gi]),
            .flg_d (flg_d[gi])
        );
    end

    dirq_master_eval u_master (
        .glb       (ctrl_d[GLB_BIT]),
        .force_err (ctrl_d[FORCE_BIT]),
        .flg       (flg_d),
        .mst_q     (state_q.mst),
        .mst_d     (mst_d),
        .irq_d     (irq_d)
    );

    always_comb begin
        state_d      = state_q;
        state_d.ctrl = ctrl_d;
        state_d.flg  = flg_d;
        state_d.mst  = mst_d;
        state_d.irq  = irq_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_data                    = state_q.ctrl;
        rd_data[FLG_LSB +: CH_N]   = state_q.flg;
        rd_data[MST_BIT]           = state_q.mst;
    end

    assign irq_req = state_q.irq;

endmodule

// File: rtl/dirq_checker.sv
module dirq_checker
    import dirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             irq_req
);

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !irq_req));

    assert_write_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[23:0] == ($past(wr_data[23:0]) & WR_MASK[23:0])));

    assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[FLG_LSB +: CH_N] & ~$past(rd_data[FLG_LSB +: CH_N])
                     & ~$past(rd_data[EN_LSB +: CH_N])) == '0));

    assert_master_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[MST_BIT] == ((rd_data[GLB_BIT] && (|rd_data[FLG_LSB +: CH_N])) || rd_data[FORCE_BIT]));

    assert_req_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $rose(rd_data[MST_BIT]));

    assert_rise_gives_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[MST_BIT]) |-> irq_req);

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

endmodule

bind dma_irq_ctrl dirq_checker u_dirq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_req (irq_req)
);

// File: tb/dma_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dma_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  ch_done = '0;
    logic [31:0] rd_data;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model = '0;

    always #5 clk = ~clk;

    dma_irq_ctrl u_dma_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ch_done (ch_done),
        .rd_data (rd_data),
        .irq_req (irq_req)
    );

    // Expected next register word and request bit, from the requirements.
    function automatic logic [32:0] ref_next(input logic [31:0] cur, input logic w,
                                             input logic [31:0] d, input logic [6:0] dn);
        logic [31:0] ctl;
        logic [6:0]  flg;
        logic        cond;
        ctl = w ? (d & 32'h00FF803F) : (cur & 32'h00FF803F);
        flg = cur[30:24];
        if (w) flg = flg & ~d[30:24];
        flg = flg | (dn & cur[22:16]);
        cond = (ctl[23] && (|flg)) || ctl[15];
        return {cond && !cur[31], cond, flg, ctl[23:0]};
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq_req actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives, lets one rising edge pass, checks at the next falling edge.
    task automatic step(input logic w, input logic [31:0] d, input logic [6:0] dn, input string tag);
        logic [32:0] nx;
        nx = ref_next(model, w, d, dn);
        wr_en   = w;
        wr_data = d;
        ch_done = dn;
        @(negedge clk);
        model = nx[31:0];
        check32(tag, rd_data, nx[31:0]);
        check1(tag, irq_req, nx[32]);
        wr_en   = 1'b0;
        ch_done = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check32("R1", rd_data, 32'h0);
        check1("R1", irq_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1", rd_data, 32'h0);
        check1("R1", irq_req, 1'b0);

        step(1'b1, 32'hFFFF_FFFF, 7'h00, "R2");   // forced error -> 80FF803F with request
        step(1'b1, 32'h0000_0000, 7'h00, "R9");   // condition false, master drops
        step(1'b1, 32'h8000_0000, 7'h00, "R6");   // bit 31 not writable
        step(1'b1, 32'h0001_0000, 7'h00, "R2");   // enable channel 0 only
        step(1'b0, 32'h0,         7'h03, "R4");   // only channel 0 flag sets
        step(1'b1, 32'h0083_0000, 7'h00, "R6");   // global on with flag pending -> request
        step(1'b0, 32'h0,         7'h02, "R8");   // new flag, master held, no request
        step(1'b1, 32'h0283_0000, 7'h00, "R3");   // clear channel 1 only, channel 0 kept
        step(1'b1, 32'h0183_0000, 7'h01, "R5");   // clear and set together: set wins
        step(1'b1, 32'h0183_0000, 7'h00, "R9");   // clear last flag, master drops
        step(1'b0, 32'h0,         7'h02, "R9");   // re-trigger gives new request
        step(1'b1, 32'h7F00_0000, 7'h00, "R3");   // clear all flags and controls

        for (int i = 0; i < 4000; i++) begin
            d = $urandom;
            d[30:24] = d[30:24] & 7'($urandom) & 7'($urandom);
            if ($urandom_range(7) != 0) d[15] = 1'b0;
            step(($urandom_range(2) == 0), d, 7'($urandom) & 7'($urandom), "R6");
        end

        finish_run();
    end

endmodule